// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block answers as a slave on a two-wire serial bus and holds a 512 x 8 byte store. It spots bus START and STOP conditions and receives bytes MSB first. It drives acknowledge and, on reads, shifts stored bytes back out. The block's own fast clock samples both bus lines after a pair of synchronizer flops. SDA leaves the block as an open-drain enable: a high `sda_oe` pulls the line low.

A single 9-bit address counter serves every operation. A write transaction sends three kinds of byte. The select byte carries the top address bit. The byte after it gives the low eight address bits. Each byte after that is stored at the counter, and the counter then steps by one. If the write stops after the address byte, it only moves the counter. A repeated START with a read select byte then reads from that address. Each read returns the byte at the counter and then steps the counter, wrapping from 511 to 0. A master acknowledge asks for the next byte, and a missing acknowledge ends the read.

An external write controller drives `busy_i` while the stored data is being committed. While it is high the block ignores the bus and gives no acknowledge, so a master can poll for completion with a select byte.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. After a STOP the block releases SDA and acknowledges nothing until the next START.
- R2: The select byte, MSB first, is type code 1010, then A2, then A1, then the page bit, then the direction bit. If the type code or either strap bit does not match, the block gives no acknowledge and ignores the bus until the next START.
- R3: In a write transaction the block pulls SDA low during the ninth clock after each byte: the select byte, the address byte and every data byte.
- R4: A write select byte loads its page bit into counter bit 8, and the next byte loads counter bits 7:0. Each data byte after that is stored at the counter, and the counter then steps by one.
- R5: A read select byte leaves the counter unchanged, so its page bit has no effect. The read returns the byte at the counter, which holds the last accessed address plus one.
- R6: A write that ends after the address byte, followed by a repeated START and a read select byte, reads from the address just loaded.
- R7: A master acknowledge (SDA low on the ninth clock) after a read byte brings the next byte. A missing acknowledge ends the read and SDA is released.
- R8: The counter wraps from 511 to 0, both when reading and when storing.
- R9: While busy_i is high the block gives no acknowledge and stores nothing. Once busy_i falls, the stored contents are unchanged.
- R10: The block samples SDA on SCL rising. It starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_a2 | input | 1 | Select strap compared with select byte bit 3 |
| strap_a1 | input | 1 | Select strap compared with select byte bit 2 |
| busy_i | input | 1 | Write cycle in progress, from the write controller |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
The hardest conditions to reach from the ports are the counter wrap at the top of the store and the dummy-write random read. The wrap has to happen both in a burst of stored bytes and in a sequential read. The stimulus starts a five-byte write two locations below the top, so both the storing and the reading runs cross the 511-to-0 boundary. A repeated START then moves straight into a four-byte sequential read, and a current-address read afterwards shows where the counter was left. The busy case is reached by raising busy_i around a full write transaction. A later random read then shows the earlier byte unchanged.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } eep_state_t;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_WADDR,
      PH_WDATA
   } eep_phase_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int W       = 2,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eep_sync needs at least two stages");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {STAGES{RST_VAL}};
         else        ff <= {ff[STAGES-2:0], d[i]};
      end
      assign q[i] = ff[STAGES-1];
   end
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/eep_fsm.sv
module eep_fsm
   import eep_pkg::*;
#(
   parameter int         AW       = 9,
   parameter int         DW       = 8,
   parameter logic [3:0] DEV_CODE = 4'b1010
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic          strap_a2,
   input  logic          strap_a1,
   input  logic          busy_i,
   input  logic [DW-1:0] ram_q,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output logic [DW-1:0] ram_wdata,
   output logic [AW-1:0] ram_raddr,
   output logic          sda_oe
);
   localparam int BCW = $clog2(DW + 1);

   eep_state_t    st;
   eep_phase_t    ph;
   logic          scl_d, sda_d;
   logic [BCW-1:0] bitcnt;
   logic [DW-1:0] sh;
   logic [AW-1:0] addr_q;
   logic          go_rd, mack_q, oe_q;

   logic scl_rise, scl_fall, start_ev, stop_ev, dev_hit, load_rd;

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
   assign dev_hit  = (sh[DW-1:DW-4] == DEV_CODE) && (sh[3] == strap_a2) && (sh[2] == strap_a1);
   assign load_rd  = ~busy_i & ~start_ev & ~stop_ev & scl_fall &
                     (((st == ST_ACK) & go_rd) | ((st == ST_MACK) & mack_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_DEV;
         bitcnt    <= '0;
         sh        <= '0;
         addr_q    <= '0;
         go_rd     <= 1'b0;
         mack_q    <= 1'b0;
         oe_q      <= 1'b0;
         ram_we    <= 1'b0;
         ram_waddr <= '0;
         ram_wdata <= '0;
      end else begin
         ram_we <= 1'b0;
         if (busy_i) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (start_ev) begin
            st     <= ST_RX;
            ph     <= PH_DEV;
            bitcnt <= '0;
            oe_q   <= 1'b0;
         end else if (stop_ev) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (load_rd) begin
            sh     <= ram_q;
            oe_q   <= ~ram_q[DW-1];
            addr_q <= addr_q + AW'(1);
            bitcnt <= '0;
            st     <= ST_TX;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     sh     <= {sh[DW-2:0], sda_s};
                     bitcnt <= bitcnt + BCW'(1);
                  end else if (scl_fall && bitcnt == BCW'(DW)) begin
                     bitcnt <= '0;
                     go_rd  <= 1'b0;
                     case (ph)
                        PH_DEV: begin
                           if (dev_hit) begin
                              oe_q  <= 1'b1;
                              st    <= ST_ACK;
                              go_rd <= sh[0];
                              ph    <= PH_WADDR;
                              if (!sh[0]) addr_q[AW-1] <= sh[1];
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        PH_WADDR: begin
                           addr_q[DW-1:0] <= sh;
                           oe_q <= 1'b1;
                           st   <= ST_ACK;
                           ph   <= PH_WDATA;
                        end
                        default: begin
                           ram_we    <= 1'b1;
                           ram_waddr <= addr_q;
                           ram_wdata <= sh;
                           addr_q    <= addr_q + AW'(1);
                           oe_q      <= 1'b1;
                           st        <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     oe_q <= 1'b0;
                     st   <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == BCW'(DW - 1)) begin
                        oe_q <= 1'b0;
                        st   <= ST_MACK;
                     end else begin
                        sh     <= {sh[DW-2:0], 1'b0};
                        oe_q   <= ~sh[DW-2];
                        bitcnt <= bitcnt + BCW'(1);
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack_q <= ~sda_s;
                  else if (scl_fall) st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign ram_raddr = addr_q;
   assign sda_oe    = oe_q;

   p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ev && !busy_i && !start_ev) |=> (st == ST_IDLE && !oe_q));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !oe_q);

   p_rollover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_rd && addr_q == '1) |=> (addr_q == '0));

   p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> (!oe_q && !ram_we));

   p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_s);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
   parameter int         ADDR_W      = 9,
   parameter int         DATA_W      = 8,
   parameter logic [3:0] DEV_CODE    = 4'b1010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic strap_a2,
   input  logic strap_a1,
   input  logic busy_i,
   output logic sda_oe
);
   if (DATA_W != 8) begin : g_bad_data
      $error("select byte layout needs an 8-bit data width");
   end
   if (ADDR_W != DATA_W + 1) begin : g_bad_addr
      $error("address width must be one page bit above the data width");
   end

   logic [1:0]        bus_s;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_waddr, ram_raddr;
   logic [DATA_W-1:0] ram_wdata, ram_q;

   eep_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   eep_fsm #(.AW(ADDR_W), .DW(DATA_W), .DEV_CODE(DEV_CODE)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (bus_s[1]),
      .sda_s     (bus_s[0]),
      .strap_a2  (strap_a2),
      .strap_a1  (strap_a1),
      .busy_i    (busy_i),
      .ram_q     (ram_q),
      .ram_we    (ram_we),
      .ram_waddr (ram_waddr),
      .ram_wdata (ram_wdata),
      .ram_raddr (ram_raddr),
      .sda_oe    (sda_oe)
   );

   eep_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ram_waddr),
      .wdata (ram_wdata),
      .raddr (ram_raddr),
      .rdata (ram_q)
   );
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic busy = 1'b0;
   logic a2 = 1'b1;
   logic a1 = 1'b0;
   logic sda_oe;
   logic sda_bus;

   int checks = 0;
   int errors = 0;
   int viol = 0;
   bit done = 1'b0;

   logic [7:0] mdl [512];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] got;
   event       got_ev;

   assign sda_bus = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   i2c_eeprom_slave u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_bus),
      .strap_a2 (a2),
      .strap_a1 (a1),
      .busy_i   (busy),
      .sda_oe   (sda_oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic qw();
      repeat (8) @(negedge clk);
   endtask

   task automatic start_c();
      m_sda = 1'b1; qw();
      scl = 1'b1;   qw();
      m_sda = 1'b0; qw();
      scl = 1'b0;   qw();
   endtask

   task automatic stop_c();
      m_sda = 1'b0; qw();
      scl = 1'b1;   qw();
      m_sda = 1'b1; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; qw();
         scl = 1'b1;   qw(); qw();
         scl = 1'b0;
      end
      m_sda = 1'b1; qw();
      scl = 1'b1;   qw();
      ack = !sda_bus;
      qw();
      scl = 1'b0;   qw();
   endtask

   task automatic recv_byte(input bit mack);
      logic [7:0] b;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw();
         scl = 1'b1; qw();
         b[i] = sda_bus;
         qw();
         scl = 1'b0;
      end
      m_sda = mack ? 1'b0 : 1'b1; qw();
      scl = 1'b1; qw(); qw();
      scl = 1'b0; qw();
      m_sda = 1'b1;
      got = b;
      -> got_ev;
   endtask

   function automatic logic [7:0] dev(input bit b8, input bit rw);
      return {4'b1010, a2, a1, b8, rw};
   endfunction

   task automatic expect_rd(input logic [7:0] v, input string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   // dummy write to load the counter, then a repeated START into read
   task automatic rd_setup(input logic [8:0] a, input string tag);
      bit ack;
      start_c();
      send_byte(dev(a[8], 1'b0), ack); chk({tag, " select ack"}, ack, 1);
      send_byte(a[7:0], ack);          chk({tag, " address ack"}, ack, 1);
      start_c();
      send_byte(dev(1'b0, 1'b1), ack); chk({tag, " read select ack"}, ack, 1);
   endtask

   // scoreboard monitor
   always @(got_ev) begin
      if (exp_q.size() == 0) begin
         chk("R7 unexpected read byte", got, 0);
      end else begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, got, e);
      end
   end

   always @(posedge sda_oe) if (scl) viol++;

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      finish_up();
   end

   initial begin
      bit ack;
      logic [7:0] pg [5];
      pg[0] = 8'h11; pg[1] = 8'h22; pg[2] = 8'h33; pg[3] = 8'h44; pg[4] = 8'h77;

      repeat (10) @(negedge clk);
      chk("R1 reset release", sda_oe, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R3 R4 single byte write at 0x105
      start_c();
      send_byte(dev(1'b1, 1'b0), ack); chk("R3 select ack", ack, 1);
      send_byte(8'h05, ack);           chk("R3 address ack", ack, 1);
      send_byte(8'hA5, ack);           chk("R3 data ack", ack, 1);
      stop_c();
      mdl[9'h105] = 8'hA5;

      // R8 R4 five-byte write from 0x1FE, wraps to 0x002
      start_c();
      send_byte(dev(1'b1, 1'b0), ack); chk("R4 select ack", ack, 1);
      send_byte(8'hFE, ack);           chk("R4 address ack", ack, 1);
      for (int k = 0; k < 5; k++) begin
         send_byte(pg[k], ack);
         chk("R3 burst data ack", ack, 1);
         mdl[9'(9'h1FE + k)] = pg[k];
      end
      stop_c();

      // R6 R7 R8 random then sequential read across 511 -> 0
      rd_setup(9'h1FE, "R6");
      expect_rd(mdl[9'h1FE], "R6 first byte");
      expect_rd(mdl[9'h1FF], "R7 second byte");
      expect_rd(mdl[9'h000], "R8 wrapped byte");
      expect_rd(mdl[9'h001], "R8 after wrap");
      recv_byte(1'b1);
      recv_byte(1'b1);
      recv_byte(1'b1);
      recv_byte(1'b0);
      qw();
      chk("R7 released after no-ack", sda_oe, 0);
      stop_c();

      // R5 current address read, page bit in select byte ignored
      start_c();
      send_byte(dev(1'b1, 1'b1), ack); chk("R5 read select ack", ack, 1);
      expect_rd(mdl[9'h002], "R5 current address byte");
      recv_byte(1'b0);
      stop_c();

      // R6 random read of the single byte
      rd_setup(9'h105, "R6");
      expect_rd(mdl[9'h105], "R6 random byte");
      recv_byte(1'b0);
      stop_c();

      // R2 wrong type code, then wrong strap
      start_c();
      send_byte(8'hB2, ack);           chk("R2 wrong type nack", ack, 0);
      send_byte(8'h05, ack);           chk("R2 stays idle", ack, 0);
      stop_c();
      start_c();
      send_byte({4'b1010, 1'b0, 1'b0, 1'b1, 1'b0}, ack); chk("R2 wrong strap nack", ack, 0);
      stop_c();

      // R1 no START after STOP: no acknowledge
      scl = 1'b0; qw();
      send_byte(dev(1'b1, 1'b0), ack); chk("R1 no start nack", ack, 0);
      stop_c();

      // R9 busy: no ack, nothing stored
      busy = 1'b1;
      start_c();
      send_byte(dev(1'b1, 1'b0), ack); chk("R9 busy select nack", ack, 0);
      send_byte(8'h05, ack);           chk("R9 busy address nack", ack, 0);
      send_byte(8'h00, ack);           chk("R9 busy data nack", ack, 0);
      stop_c();
      busy = 1'b0;
      repeat (4) @(negedge clk);
      rd_setup(9'h105, "R9");
      expect_rd(mdl[9'h105], "R9 contents unchanged");
      recv_byte(1'b0);
      stop_c();

      qw();
      chk("R10 drive only while SCL low", viol, 0);
      chk("R7 scoreboard drained", exp_q.size(), 0);
      finish_up();
   end
endmodule